// File: doc/BRIEF.md
# RAM-Backed Ternary Rule Matcher

This block answers ternary rule lookups without a comparator per rule. A search key of `KEY_W` bits is cut into slices of `SLICE_W` bits. Each slice drives the read address of its own small RAM, which has one word per possible slice value. Every word carries one bit per rule, and that bit says whether the rule accepts that slice value. Bits that a rule does not care about are encoded by setting the rule's bit in every word that the slice can address.

The words read from all slice RAMs are combined with a bitwise AND, so a rule survives only if every slice accepts it. A priority encoder then reports whether any rule survived and which surviving rule has the lowest number. A new search may enter on every clock cycle, and each result leaves three register stages later together with its valid flag.

An external update controller fills the RAMs through a single write port, one word per cycle. It chooses the slice RAM, the word address and the full rule bitmap for that word.

Top module: `tcam_sram_lookup`

## Requirements
- R1: After reset every RAM word is zero and `res_valid` is 0; a search issued before any write returns `res_hit`=0, `res_match`=0 and `res_index`=0.
- R2: Slice k of the key is bits [k*SLICE_W +: SLICE_W], with slice 0 the least significant, and it is the read address of RAM k.
- R3: Bit i of a RAM word belongs to rule i; a 1 means rule i accepts that slice value.
- R4: `res_match` equals the bitwise AND of the words read from all slice RAMs for that key.
- R5: A search sampled on a rising edge appears on the outputs after the third rising edge, counting the sampling edge as the first. `res_valid` is a copy of `srch_valid` delayed by three cycles, and back-to-back searches are accepted.
- R6: When any bit of `res_match` is set, `res_hit` is 1 and `res_index` is the lowest set bit position.
- R7: When `res_match` is zero, `res_hit` is 0 and `res_index` is 0.
- R8: With `wr_en` high at a rising edge, word `wr_addr` of RAM `wr_slice` takes `wr_data`. No other word changes.
- R9: A search sampled on the same edge as a write to the word it addresses reads the contents from before the write. The next search reads the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_valid | input | 1 | A search key is present |
| srch_key | input | KEY_W | Search key |
| wr_en | input | 1 | Write one RAM word |
| wr_slice | input | SEL_W | Which slice RAM is written |
| wr_addr | input | SLICE_W | Word address inside that RAM |
| wr_data | input | RULES | Rule bitmap to store |
| res_valid | output | 1 | Result belongs to a valid search |
| res_hit | output | 1 | At least one rule matched |
| res_index | output | IDX_W | Lowest matching rule number |
| res_match | output | RULES | Per-rule match vector |

## Verification
The bench builds the block with KEY_W=8, SLICE_W=2 and RULES=16, which gives four RAMs of four words each. With only 256 possible keys, every key can be searched against each loaded rule set. The bench keeps its own copy of all sixteen RAM words, so each expected match vector and lowest index is computed by plain arithmetic. It also places a write and a search on the same edge, and it interleaves idle cycles among back-to-back searches to check that the valid flag stays aligned with its data.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
   // Width of a select/index field able to count n items (never zero).
   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tcam_slice_ram.sv
module tcam_slice_ram #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Read and write share one edge; the read sees the old word.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
         rd_data <= '0;
      end else begin
         rd_data <= mem[rd_addr];
         if (wr_en) mem[wr_addr] <= wr_data;
      end
   end

   p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en)) |-> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/tcam_and_stage.sv
module tcam_and_stage #(
   parameter int SLICES = 4,
   parameter int RULES  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          v_i,
   input  logic [SLICES-1:0][RULES-1:0]  words_i,
   output logic                          v_o,
   output logic [RULES-1:0]              and_o
);
   logic [SLICES:0][RULES-1:0] acc;
   assign acc[0] = '1;

   for (genvar k = 0; k < SLICES; k++) begin : g_acc
      assign acc[k+1] = acc[k] & words_i[k];

      p_and_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && v_o) |-> ((and_o & ~$past(words_i[k])) == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         and_o <= '0;
      end else begin
         v_o   <= v_i;
         and_o <= acc[SLICES];
      end
   end
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
   parameter int RULES = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_i,
   input  logic [RULES-1:0] m_i,
   output logic             v_o,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [RULES-1:0] m_o
);
   logic [IDX_W-1:0] idx_c;

   // Scan from the top so the lowest set bit is written last and wins.
   always_comb begin
      idx_c = '0;
      for (int i = RULES - 1; i >= 0; i--)
         if (m_i[i]) idx_c = IDX_W'(i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         hit_o <= 1'b0;
         idx_o <= '0;
         m_o   <= '0;
      end else begin
         v_o   <= v_i;
         hit_o <= |m_i;
         idx_o <= idx_c;
         m_o   <= m_i;
      end
   end

   p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (m_o[idx_o] &&
                 ((m_o & ((RULES'(1) << idx_o) - RULES'(1))) == '0)));

   p_miss_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> (idx_o == '0 && m_o == '0));
endmodule

// File: rtl/tcam_sram_lookup.sv
module tcam_sram_lookup #(
   parameter int KEY_W   = 8,
   parameter int SLICE_W = 2,
   parameter int RULES   = 16,
   localparam int SLICES = KEY_W / SLICE_W,
   localparam int SEL_W  = tcam_pkg::sel_width(SLICES),
   localparam int IDX_W  = tcam_pkg::sel_width(RULES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               srch_valid,
   input  logic [KEY_W-1:0]   srch_key,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_slice,
   input  logic [SLICE_W-1:0] wr_addr,
   input  logic [RULES-1:0]   wr_data,
   output logic               res_valid,
   output logic               res_hit,
   output logic [IDX_W-1:0]   res_index,
   output logic [RULES-1:0]   res_match
);
   if (KEY_W % SLICE_W != 0) begin : g_bad_split
      $error("KEY_W must be a multiple of SLICE_W");
   end
   if (SLICE_W < 1 || SLICE_W > 12) begin : g_bad_slice
      $error("SLICE_W out of range");
   end
   if (RULES < 1) begin : g_bad_rules
      $error("RULES must be at least 1");
   end

   logic [SLICES-1:0][RULES-1:0] rd_words;
   logic                         v_rd;
   logic                         v_and;
   logic [RULES-1:0]             and_vec;

   for (genvar k = 0; k < SLICES; k++) begin : g_slice
      tcam_slice_ram #(.ADDR_W(SLICE_W), .DATA_W(RULES)) u_ram (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en && (wr_slice == SEL_W'(k))),
         .wr_addr (wr_addr),
         .wr_data (wr_data),
         .rd_addr (srch_key[k*SLICE_W +: SLICE_W]),
         .rd_data (rd_words[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_rd <= 1'b0;
      else        v_rd <= srch_valid;
   end

   tcam_and_stage #(.SLICES(SLICES), .RULES(RULES)) u_and (
      .clk     (clk),
      .rst_n   (rst_n),
      .v_i     (v_rd),
      .words_i (rd_words),
      .v_o     (v_and),
      .and_o   (and_vec)
   );

   tcam_prio_enc #(.RULES(RULES), .IDX_W(IDX_W)) u_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .v_i   (v_and),
      .m_i   (and_vec),
      .v_o   (res_valid),
      .hit_o (res_hit),
      .idx_o (res_index),
      .m_o   (res_match)
   );

   p_valid_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3))
         |-> (res_valid == $past(srch_valid, 3)));

   p_hit_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit == (res_match != '0));
endmodule

// File: tb/tcam_sram_lookup_bench.sv
module tcam_sram_lookup_bench;
   localparam int KW   = 8;
   localparam int CW   = 2;
   localparam int NR   = 16;
   localparam int NS   = KW / CW;
   localparam int DEP  = 1 << CW;
   localparam int SW   = 2;
   localparam int IW   = 4;
   localparam int NKEY = 1 << KW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          srch_valid = 1'b0;
   logic [KW-1:0] srch_key = '0;
   logic          wr_en = 1'b0;
   logic [SW-1:0] wr_slice = '0;
   logic [CW-1:0] wr_addr = '0;
   logic [NR-1:0] wr_data = '0;
   logic          res_valid, res_hit;
   logic [IW-1:0] res_index;
   logic [NR-1:0] res_match;

   int n_chk = 0;
   int n_bad = 0;
   logic [NR-1:0] bm [NS][DEP];

   always #2.5 clk = ~clk;

   tcam_sram_lookup #(.KEY_W(KW), .SLICE_W(CW), .RULES(NR)) u_tcam_sram_lookup (
      .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_key(srch_key),
      .wr_en(wr_en), .wr_slice(wr_slice), .wr_addr(wr_addr), .wr_data(wr_data),
      .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index),
      .res_match(res_match));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NR-1:0] exp_match(input logic [KW-1:0] key);
      logic [NR-1:0] m = '1;
      for (int k = 0; k < NS; k++) m &= bm[k][(key >> (k * CW)) & (DEP - 1)];
      return m;
   endfunction

   function automatic int low_bit(input logic [NR-1:0] m);
      for (int i = 0; i < NR; i++) if (m[i]) return i;
      return 0;
   endfunction

   task automatic wr(input int k, input int a, input logic [NR-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_slice = SW'(k); wr_addr = CW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      bm[k][a] = d;
   endtask

   function automatic logic [KW-1:0] rule_val(input int set, input int i);
      if (set == 0) return KW'(i * 37);
      return KW'(8'h5A ^ (i * 11));
   endfunction

   function automatic logic [KW-1:0] rule_care(input int set, input int i);
      if (set == 0) return (i % 3 == 0) ? 8'hF0 : (8'hFF ^ KW'(3 << (2 * (i % 4))));
      return KW'(8'hFF << (i % 6));
   endfunction

   // R3: bit i of word a in slice k is 1 iff rule i accepts value a there.
   task automatic load_rules(input int set);
      for (int k = 0; k < NS; k++)
         for (int a = 0; a < DEP; a++) begin
            logic [NR-1:0] w = '0;
            for (int i = 0; i < NR; i++) begin
               logic [KW-1:0] v = rule_val(set, i) >> (k * CW);
               logic [KW-1:0] c = rule_care(set, i) >> (k * CW);
               w[i] = (((KW'(a) ^ v) & c & KW'(DEP - 1)) == '0);
            end
            wr(k, a, w);
         end
   endtask

   // Every key once; with gap>0 every gap-th cycle is idle.
   task automatic sweep(input int gap);
      bit            v_h [NKEY];
      logic [KW-1:0] k_h [NKEY];
      for (int t = 0; t < NKEY + 3; t++) begin
         @(negedge clk);
         if (t >= 3) begin
            int j = t - 3;
            logic [NR-1:0] e = exp_match(k_h[j]);
            chk("R5 res_valid tracks srch_valid", 32'(res_valid), 32'(v_h[j]));
            if (v_h[j]) begin
               chk("R2/R4 match vector", 32'(res_match), 32'(e));
               chk(e != 0 ? "R6 hit flag" : "R7 miss flag", 32'(res_hit), 32'(e != 0));
               chk(e != 0 ? "R6 lowest index" : "R7 index on miss",
                   32'(res_index), 32'(low_bit(e)));
            end
         end
         if (t < NKEY) begin
            v_h[t] = (gap == 0) || ((t % gap) != gap - 1);
            k_h[t] = KW'(t);
            srch_valid = v_h[t];
            srch_key = k_h[t];
         end else srch_valid = 1'b0;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < NS; k++) for (int a = 0; a < DEP; a++) bm[k][a] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 res_valid after reset", 32'(res_valid), 0);
      chk("R1 res_hit after reset", 32'(res_hit), 0);
      // R1: empty RAMs, nothing matches any key.
      sweep(0);

      load_rules(0);
      sweep(5);
      load_rules(1);
      sweep(0);

      // R8: single-word writes; the sweep compares every other word too.
      wr(1, 2, 16'hFFFF);
      wr(3, 0, 16'h8421);
      sweep(3);

      // R9: write and search on the same edge.
      for (int k = 0; k < NS; k++) wr(k, 0, 16'h00F0);
      @(negedge clk);
      srch_valid = 1'b1; srch_key = '0;
      wr_en = 1'b1; wr_slice = '0; wr_addr = '0; wr_data = '0;
      @(negedge clk);
      wr_en = 1'b0; bm[0][0] = '0;
      @(negedge clk);
      srch_valid = 1'b0;
      @(negedge clk);
      chk("R9 same-edge search sees old word", 32'(res_match), 32'h00F0);
      chk("R9 old word lowest index", 32'(res_index), 4);
      @(negedge clk);
      chk("R9 next search sees new word", 32'(res_match), 0);
      chk("R9 next search miss", 32'(res_hit), 0);
      chk("R8 other slice word kept", 32'(bm[1][0]), 32'h00F0);
      sweep(0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule